// File: doc/BRIEF.md
# Command Frame Parser

This block interprets a command frame that a serial receiver has already written into a word-wide RAM. A single start pulse, given once the transfer is complete, makes the parser fetch 16-bit words one at a time from address zero upward. It checks the first two words against a fixed sync pattern, then decodes the third word as a command. The command selects one of two modes: waveform generation, which carries parameters, or storage of user samples into one of four user regions.

In generation mode the parser goes on to fetch four more words. These hold a 32-bit frequency word split over two words, an amplitude word, and a phase word, which serves as the duty cycle for square waves. It reports the result with a one-cycle valid pulse. In store mode it reports the target region as soon as the command word has been decoded; the sample copy that follows is left to a separate engine. Any bad sync word, bad region field or unknown waveform code ends parsing with a one-cycle error pulse. Reads use a RAM port whose read latency is a fixed parameter, and only one read is in flight at a time.

Top module: `cmd_frame_parser`

## Requirements
- R1: After a start pulse the block reads RAM words in strictly ascending address order beginning at address 0. Each read is a one-cycle `ramRdEn` pulse, and the next read is issued only after the previous data has returned. A start pulse that arrives while a frame is being parsed is ignored and produces no extra reads and no extra strobe.
- R2: If word 0 is not 16'hAAF0, the block pulses `paramError` after exactly one read and issues no further read.
- R3: If word 0 matches but word 1 is not 16'hBB55, the block pulses `paramError` after exactly two reads.
- R4: If bit 15 of word 2 is 1 (store mode) and the field in bits [14:8] holds 0 to 3, the block pulses `paramValid` after three reads. It drives `storeMode`=1 and `userRegion` = that field, so 0 means region 1 and 3 means region 4. A field value of 4 or more gives `paramError` after three reads.
- R5: If bit 15 of word 2 is 0 (generate mode), bits [14:11] are the waveform code: 1 sine, 2 square, 3 triangle, 4 sawtooth, 5 Gaussian noise, and 6 to 9 user regions 1 to 4. The code appears on `waveType` with `storeMode`=0. Codes 0 and 10 to 15 give `paramError` after three reads, with no parameter read. Bits [10:0] of word 2 have no effect in generate mode.
- R6: In generate mode `freqWord` = {word 3, word 4}, so word 3 supplies bits [31:16].
- R7: In generate mode `ampWord` = word 5 and `phaseWord` = word 6, after exactly seven reads.
- R8: Each accepted start produces exactly one strobe. `paramValid` and `paramError` are never high together, and each is a single-cycle pulse. `paramValid` rises only once every output field of the frame is already registered.
- R9: After reset all outputs are zero and no read is issued until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: frame is present in RAM |
| ramRdEn | output | 1 | Read request to the RAM |
| ramAddr | output | ADDR_W | Word address of the read |
| ramRdData | input | 16 | Read data, valid RD_LAT cycles after the request |
| paramValid | output | 1 | One-cycle pulse: frame accepted, fields valid |
| paramError | output | 1 | One-cycle pulse: frame rejected |
| storeMode | output | 1 | 1 = store into user region, 0 = generate |
| waveType | output | 4 | Waveform code in generate mode |
| userRegion | output | 2 | Target user region minus one in store mode |
| freqWord | output | 32 | Frequency word in generate mode |
| ampWord | output | 16 | Amplitude word in generate mode |
| phaseWord | output | 16 | Phase word, or duty cycle for square waves |

## Verification
The bench builds the parser with RD_LAT = 3 and ADDR_W = 18. A three-cycle read latency keeps every frame spread over many cycles, which leaves time for a second start pulse to land mid-frame and shows whether it is ignored. It also means that latching data one cycle early or late captures the wrong word, which the field comparisons then expose. The bench models the RAM with that latency, logs every read address, and compares read counts, fields and strobes against expectations computed from the frame words.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;

  localparam logic [15:0] SYNC_FIRST  = 16'hAAF0;
  localparam logic [15:0] SYNC_SECOND = 16'hBB55;
  localparam int          LAST_WORD   = 6;
  localparam int          IDX_W       = $clog2(LAST_WORD + 1);

  typedef enum logic [3:0] {
    WAVE_NONE   = 4'd0,
    WAVE_SINE   = 4'd1,
    WAVE_SQUARE = 4'd2,
    WAVE_TRI    = 4'd3,
    WAVE_SAW    = 4'd4,
    WAVE_NOISE  = 4'd5,
    WAVE_USER1  = 4'd6,
    WAVE_USER2  = 4'd7,
    WAVE_USER3  = 4'd8,
    WAVE_USER4  = 4'd9
  } wave_e;

  typedef struct packed {
    logic rdReq;
    logic clrIdx;
    logic incIdx;
    logic ldCmd;
    logic ldFreqHi;
    logic ldFreqLo;
    logic ldAmp;
    logic ldPhase;
    logic finishOk;
    logic finishErr;
  } ctl_strobes_t;

endpackage

// File: rtl/cmd_frame_ctrl.sv
module cmd_frame_ctrl
  import cmd_frame_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             isSyncFirst,
  input  logic             isSyncSecond,
  input  logic             cmdStore,
  input  logic             regionOk,
  input  logic             codeOk,
  output ctl_strobes_t     strb
);

  localparam int CNT_W = $clog2(RD_LAT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT} state_e;

  state_e     state, stateNext;
  logic [CNT_W-1:0] latCnt;
  logic       dataReady;

  assign dataReady = (state == ST_WAIT) && (latCnt == CNT_W'(RD_LAT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      latCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_READ)
        latCnt <= CNT_W'(1);
      else if (state == ST_WAIT && !dataReady)
        latCnt <= latCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.clrIdx = 1'b1;
          stateNext   = ST_READ;
        end
      end
      ST_READ: begin
        strb.rdReq = 1'b1;
        stateNext  = ST_WAIT;
      end
      ST_WAIT: begin
        if (dataReady) begin
          stateNext = ST_IDLE;
          case (wordIdx)
            IDX_W'(0): begin
              if (isSyncFirst) begin
                strb.incIdx = 1'b1;
                stateNext   = ST_READ;
              end else strb.finishErr = 1'b1;
            end
            IDX_W'(1): begin
              if (isSyncSecond) begin
                strb.incIdx = 1'b1;
                stateNext   = ST_READ;
              end else strb.finishErr = 1'b1;
            end
            IDX_W'(2): begin
              if (cmdStore) begin
                strb.ldCmd     = regionOk;
                strb.finishOk  = regionOk;
                strb.finishErr = !regionOk;
              end else if (codeOk) begin
                strb.ldCmd  = 1'b1;
                strb.incIdx = 1'b1;
                stateNext   = ST_READ;
              end else strb.finishErr = 1'b1;
            end
            IDX_W'(3): begin
              strb.ldFreqHi = 1'b1;
              strb.incIdx   = 1'b1;
              stateNext     = ST_READ;
            end
            IDX_W'(4): begin
              strb.ldFreqLo = 1'b1;
              strb.incIdx   = 1'b1;
              stateNext     = ST_READ;
            end
            IDX_W'(5): begin
              strb.ldAmp  = 1'b1;
              strb.incIdx = 1'b1;
              stateNext   = ST_READ;
            end
            IDX_W'(6): begin
              strb.ldPhase  = 1'b1;
              strb.finishOk = 1'b1;
            end
            default: strb.finishErr = 1'b1;
          endcase
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Latency counter never runs past the configured read latency (R1).
  assert_lat_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    latCnt <= CNT_W'(RD_LAT));

  // A read request is always followed by a wait, never a second request (R1).
  assert_single_outstanding_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdReq |=> (state == ST_WAIT));

endmodule

// File: rtl/cmd_frame_dpath.sv
module cmd_frame_dpath
  import cmd_frame_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobes_t      strb,
  input  logic [15:0]       ramRdData,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              isSyncFirst,
  output logic              isSyncSecond,
  output logic              cmdStore,
  output logic              regionOk,
  output logic              codeOk,
  output logic              paramValid,
  output logic              paramError,
  output logic              storeMode,
  output logic [3:0]        waveType,
  output logic [1:0]        userRegion,
  output logic [31:0]       freqWord,
  output logic [15:0]       ampWord,
  output logic [15:0]       phaseWord
);

  logic [3:0] codeField;

  assign ramRdEn      = strb.rdReq;
  assign ramAddr      = {{(ADDR_W-IDX_W){1'b0}}, wordIdx};
  assign isSyncFirst  = (ramRdData == SYNC_FIRST);
  assign isSyncSecond = (ramRdData == SYNC_SECOND);
  assign cmdStore     = ramRdData[15];
  assign regionOk     = (ramRdData[14:10] == 5'd0);
  assign codeField    = ramRdData[14:11];
  assign codeOk       = (codeField >= 4'(WAVE_SINE)) && (codeField <= 4'(WAVE_USER4));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx    <= '0;
      storeMode  <= 1'b0;
      waveType   <= '0;
      userRegion <= '0;
      freqWord   <= '0;
      ampWord    <= '0;
      phaseWord  <= '0;
      paramValid <= 1'b0;
      paramError <= 1'b0;
    end else begin
      paramValid <= strb.finishOk;
      paramError <= strb.finishErr;
      if (strb.clrIdx)      wordIdx <= '0;
      else if (strb.incIdx) wordIdx <= wordIdx + IDX_W'(1);
      if (strb.ldCmd) begin
        storeMode <= ramRdData[15];
        if (ramRdData[15]) userRegion <= ramRdData[9:8];
        else               waveType   <= codeField;
      end
      if (strb.ldFreqHi) freqWord[31:16] <= ramRdData;
      if (strb.ldFreqLo) freqWord[15:0]  <= ramRdData;
      if (strb.ldAmp)    ampWord         <= ramRdData;
      if (strb.ldPhase)  phaseWord       <= ramRdData;
    end
  end

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEn |-> (ramAddr <= ADDR_W'(LAST_WORD)));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(paramValid && paramError));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    paramValid |=> !paramValid);

  assert_error_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    paramError |=> !paramError);

  assert_gen_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (paramValid && !storeMode) |-> (waveType >= 4'd1 && waveType <= 4'd9));

  assert_no_read_on_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (paramValid || paramError) |-> !ramRdEn);

endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
  import cmd_frame_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramAddr,
  input  logic [15:0]       ramRdData,
  output logic              paramValid,
  output logic              paramError,
  output logic              storeMode,
  output logic [3:0]        waveType,
  output logic [1:0]        userRegion,
  output logic [31:0]       freqWord,
  output logic [15:0]       ampWord,
  output logic [15:0]       phaseWord
);

  ctl_strobes_t     strb;
  logic [IDX_W-1:0] wordIdx;
  logic             isSyncFirst, isSyncSecond, cmdStore, regionOk, codeOk;

  cmd_frame_ctrl #(.RD_LAT(RD_LAT)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wordIdx(wordIdx),
    .isSyncFirst(isSyncFirst), .isSyncSecond(isSyncSecond),
    .cmdStore(cmdStore), .regionOk(regionOk), .codeOk(codeOk),
    .strb(strb)
  );

  cmd_frame_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ramRdData(ramRdData),
    .ramRdEn(ramRdEn), .ramAddr(ramAddr), .wordIdx(wordIdx),
    .isSyncFirst(isSyncFirst), .isSyncSecond(isSyncSecond),
    .cmdStore(cmdStore), .regionOk(regionOk), .codeOk(codeOk),
    .paramValid(paramValid), .paramError(paramError),
    .storeMode(storeMode), .waveType(waveType), .userRegion(userRegion),
    .freqWord(freqWord), .ampWord(ampWord), .phaseWord(phaseWord)
  );

endmodule

// File: tb/test_cmd_frame_parser.sv
module test_cmd_frame_parser;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 18;
  localparam int RD_LAT     = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic ramRdEn;
  logic [ADDR_W-1:0] ramAddr;
  logic [15:0] ramRdData;
  logic paramValid, paramError, storeMode;
  logic [3:0] waveType;
  logic [1:0] userRegion;
  logic [31:0] freqWord;
  logic [15:0] ampWord, phaseWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_parser #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) i_cmd_frame_parser (
    .clk(clk), .rstN(rstN), .start(start), .ramRdEn(ramRdEn), .ramAddr(ramAddr),
    .ramRdData(ramRdData), .paramValid(paramValid), .paramError(paramError),
    .storeMode(storeMode), .waveType(waveType), .userRegion(userRegion),
    .freqWord(freqWord), .ampWord(ampWord), .phaseWord(phaseWord)
  );

  // RAM model with fixed read latency
  logic [15:0] mem [0:7];
  logic [15:0] pipe [0:RD_LAT-1];
  always_ff @(posedge clk) begin
    pipe[0] <= ramRdEn ? mem[ramAddr[2:0]] : 16'hDEAD;
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign ramRdData = pipe[RD_LAT-1];

  typedef struct {
    bit          err;
    bit          st;
    logic [3:0]  wt;
    logic [1:0]  rg;
    logic [31:0] f;
    logic [15:0] a;
    logic [15:0] p;
    int          reads;
  } exp_t;

  exp_t expQ[$];
  int vectors = 0;
  int fails = 0;
  int readCount = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Monitor: address order, strobes, scoreboard pop
  always @(negedge clk) begin
    if (rstN) begin
      if (ramRdEn) begin
        chk("R1 read address", 32'(ramAddr), 32'(readCount));
        readCount++;
      end
      if (paramValid && paramError) chk("R8 both strobes", 32'd1, 32'd0);
      if (paramValid || paramError) begin
        if (expQ.size() == 0) chk("R8 unexpected strobe", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          chk("R8 strobe kind (1=error)", 32'(paramError), 32'(e.err));
          chk("R1 read count", 32'(readCount), 32'(e.reads));
          if (!e.err) begin
            chk("R4 storeMode", 32'(storeMode), 32'(e.st));
            if (e.st) chk("R4 userRegion", 32'(userRegion), 32'(e.rg));
            else begin
              chk("R5 waveType", 32'(waveType), 32'(e.wt));
              chk("R6 freqWord", freqWord, e.f);
              chk("R7 ampWord", 32'(ampWord), 32'(e.a));
              chk("R7 phaseWord", 32'(phaseWord), 32'(e.p));
            end
          end
        end
        readCount = 0;
      end
    end
  end

  // Driver: load frame, compute expectation, pulse start
  task automatic runFrame(input logic [15:0] w0, w1, cmd, fh, fl, am, ph, input bit dbl);
    exp_t e;
    mem[0] = w0; mem[1] = w1; mem[2] = cmd; mem[3] = fh;
    mem[4] = fl; mem[5] = am; mem[6] = ph; mem[7] = 16'h0;
    e.st = cmd[15]; e.wt = cmd[14:11]; e.rg = cmd[9:8];
    e.f = {fh, fl}; e.a = am; e.p = ph;
    if (w0 != 16'hAAF0)      begin e.err = 1; e.reads = 1; end
    else if (w1 != 16'hBB55) begin e.err = 1; e.reads = 2; end
    else if (cmd[15])        begin e.err = (cmd[14:8] >= 7'd4); e.reads = 3; end
    else if (cmd[14:11] >= 4'd1 && cmd[14:11] <= 4'd9) begin e.err = 0; e.reads = 7; end
    else                     begin e.err = 1; e.reads = 3; end
    expQ.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (dbl) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < RD_LAT; i++) pipe[i] = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state and idle without start
    @(negedge clk);
    chk("R9 paramValid", 32'(paramValid), 32'd0);
    chk("R9 paramError", 32'(paramError), 32'd0);
    chk("R9 freqWord", freqWord, 32'd0);
    chk("R9 waveType", 32'(waveType), 32'd0);
    repeat (5) @(negedge clk);
    chk("R9 no reads while idle", 32'(readCount), 32'd0);

    // R5/R6/R7: sine generate, low command bits set (ignored)
    runFrame(16'hAAF0, 16'hBB55, {1'b0, 4'd1, 11'h7FF}, 16'h1234, 16'h5678, 16'h0F0F, 16'h8001, 0);
    // R1: square with a second start mid-frame (ignored)
    runFrame(16'hAAF0, 16'hBB55, {1'b0, 4'd2, 11'h0}, 16'hFFFF, 16'h0001, 16'h7FFF, 16'h4000, 1);
    // R5: remaining codes including user regions and invalid ones
    for (int c = 0; c < 16; c++)
      runFrame(16'hAAF0, 16'hBB55, {1'b0, 4'(c), 11'h155}, 16'(c * 3), 16'hA5A5, 16'(c), 16'(~c), 0);
    // R2 / R3: bad sync words
    runFrame(16'hAAF1, 16'hBB55, 16'h0800, 16'h1, 16'h2, 16'h3, 16'h4, 0);
    runFrame(16'hAAF0, 16'hBB54, 16'h0800, 16'h1, 16'h2, 16'h3, 16'h4, 0);
    // R4: store mode regions and bad region fields
    for (int r = 0; r < 4; r++)
      runFrame(16'hAAF0, 16'hBB55, {1'b1, 7'(r), 8'hC3}, 16'h1, 16'h2, 16'h3, 16'h4, 0);
    runFrame(16'hAAF0, 16'hBB55, {1'b1, 7'd4, 8'h00}, 16'h1, 16'h2, 16'h3, 16'h4, 0);
    runFrame(16'hAAF0, 16'hBB55, {1'b1, 7'h40, 8'h00}, 16'h1, 16'h2, 16'h3, 16'h4, 0);
    // R8: frame after errors still parsed normally
    runFrame(16'hAAF0, 16'hBB55, {1'b0, 4'd9, 11'h0}, 16'hCAFE, 16'hBEEF, 16'h0102, 16'h0304, 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule